// File: doc/BRIEF.md
# Charge Status LED Blink Pattern Generator

This block drives the status indicators of a battery charger with one indicator per cell. Each output is an active-high "drive low" enable. When it is 1 the open-drain pad pulls the LED low. When it is 0 the pad is released to high-Z. The cadence shown on each output depends on two things: the charge status of that cell, and a display mode shared by all cells. The display mode comes from a select pin that is held low, left open or held high. That pin is resolved outside this block into a 2-bit code.

All timing comes from a timebase strobe that pulses for one clock every 0.16 s. Every low and high-Z interval is a whole number of strobe periods: 1, 3 or 5. Each cell has its own pattern sequencer. A sequencer samples its inputs only on a strobe, and it restarts its pattern whenever its selection changes.

Top module: `led_status_gen`

## Requirements
- R1: Status code 0 (no cell) gives high-Z on that cell's output in every display mode.
- R2: Display mode code 0 (select pin low) shows charging (code 1) as steady low. It shows maintenance (code 2) as 5 ticks low then 1 tick high-Z, repeating. It shows fault (code 3) as 3 ticks low then 3 ticks high-Z.
- R3: Display mode code 1 (select pin open) shows charging as steady low, maintenance as high-Z, and fault as 1 tick low then 1 tick high-Z.
- R4: Display mode code 2 (select pin high) shows charging as 5 ticks low then 1 tick high-Z, maintenance as steady low, and fault as 1 tick low then 1 tick high-Z.
- R5: The unused display mode code 3 gives high-Z on every output, whatever the status.
- R6: Interval lengths are counted in timebase ticks: the short interval is 1 tick, the medium interval is 3 ticks and the long interval is 5 ticks.
- R7: A sequencer acts only on a clock edge where the tick is high. When the (mode, status) pair at that edge differs from the one it is showing, it adopts the new pair and starts at the first tick of the low interval. Input changes between ticks have no effect on the output.
- R8: Reset forces every output to high-Z. The outputs stay high-Z until the first tick after reset.
- R9: Each cell has its own sequencer, so a change of one cell's status does not disturb another cell's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe every 0.16 s |
| disp_mode | input | 2 | Display mode: 0 low, 1 open, 2 high, 3 unused |
| cell_status | input | 2*NUM_CELLS | Per-cell status: 0 no cell, 1 charging, 2 maintenance, 3 fault |
| led_drive_low | output | NUM_CELLS | 1 pulls the cell's LED pad low, 0 releases it |

## Verification
A tick sampled at a rising edge sets the outputs after that same edge, so each result is due one clock after the tick. The bench raises the tick at a falling edge and drops it at the next falling edge. It samples the outputs at that second falling edge, half a clock after the update. Between ticks it holds the tick low for several cycles while it changes the inputs, and it checks that the outputs do not move until the next tick.

// File: rtl/ledpat_pkg.sv
package ledpat_pkg;

    typedef enum logic [1:0] {
        ST_NONE     = 2'd0,
        ST_CHARGING = 2'd1,
        ST_MAINT    = 2'd2,
        ST_FAULT    = 2'd3
    } cell_status_e;

    typedef enum logic [1:0] {
        DM_PIN_LOW  = 2'd0,
        DM_PIN_OPEN = 2'd1,
        DM_PIN_HIGH = 2'd2,
        DM_UNUSED   = 2'd3
    } disp_mode_e;

    typedef enum logic [1:0] {
        PK_DARK  = 2'd0,
        PK_LIT   = 2'd1,
        PK_BLINK = 2'd2
    } pat_kind_e;

    typedef enum logic [1:0] {
        DUR_SHORT = 2'd0,
        DUR_MID   = 2'd1,
        DUR_LONG  = 2'd2
    } dur_class_e;

    typedef struct packed {
        disp_mode_e   mode;
        cell_status_e status;
    } pat_sel_t;

    typedef struct packed {
        pat_kind_e  kind;
        dur_class_e low_d;
        dur_class_e rel_d;
    } pat_shape_t;

    function automatic pat_shape_t shape_of(input pat_sel_t sel);
        pat_shape_t sh;
        sh.kind  = PK_DARK;
        sh.low_d = DUR_SHORT;
        sh.rel_d = DUR_SHORT;
        if (sel.status != ST_NONE) begin
            case (sel.mode)
                DM_PIN_LOW: begin
                    case (sel.status)
                        ST_CHARGING: sh.kind = PK_LIT;
                        ST_MAINT: begin
                            sh.kind  = PK_BLINK;
                            sh.low_d = DUR_LONG;
                            sh.rel_d = DUR_SHORT;
                        end
                        default: begin
                            sh.kind  = PK_BLINK;
                            sh.low_d = DUR_MID;
                            sh.rel_d = DUR_MID;
                        end
                    endcase
                end
                DM_PIN_OPEN: begin
                    case (sel.status)
                        ST_CHARGING: sh.kind = PK_LIT;
                        ST_MAINT:    sh.kind = PK_DARK;
                        default:     sh.kind = PK_BLINK;
                    endcase
                end
                DM_PIN_HIGH: begin
                    case (sel.status)
                        ST_CHARGING: begin
                            sh.kind  = PK_BLINK;
                            sh.low_d = DUR_LONG;
                            sh.rel_d = DUR_SHORT;
                        end
                        ST_MAINT: sh.kind = PK_LIT;
                        default:  sh.kind = PK_BLINK;
                    endcase
                end
                default: sh.kind = PK_DARK;
            endcase
        end
        return sh;
    endfunction

endpackage

// File: rtl/ledpat_decode.sv
module ledpat_decode
    import ledpat_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 1,
    parameter int unsigned MID_TICKS   = 3,
    parameter int unsigned LONG_TICKS  = 5,
    parameter int unsigned CNT_W       = 3
) (
    input  pat_sel_t         sel,
    output pat_kind_e        kind,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] rel_len
);

    function automatic logic [CNT_W-1:0] dur_len(input dur_class_e d);
        case (d)
            DUR_LONG: return CNT_W'(LONG_TICKS);
            DUR_MID:  return CNT_W'(MID_TICKS);
            default:  return CNT_W'(SHORT_TICKS);
        endcase
    endfunction

    pat_shape_t shape;

    always_comb begin
        shape   = shape_of(sel);
        kind    = shape.kind;
        low_len = dur_len(shape.low_d);
        rel_len = dur_len(shape.rel_d);
    end

endmodule

// File: rtl/ledpat_phase.sv
module ledpat_phase
    import ledpat_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 1,
    parameter int unsigned MID_TICKS   = 3,
    parameter int unsigned LONG_TICKS  = 5,
    parameter int unsigned CNT_W       = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  pat_sel_t sel_in,
    output logic     drive_low
);

    pat_sel_t         sel_q;
    logic             in_low_q;
    logic [CNT_W-1:0] cnt_q;

    pat_kind_e        kind;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] rel_len;
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W:0]   cnt_inc;
    logic             sel_change;

    ledpat_decode #(
        .SHORT_TICKS (SHORT_TICKS),
        .MID_TICKS   (MID_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .CNT_W       (CNT_W)
    ) u_decode (
        .sel     (sel_q),
        .kind    (kind),
        .low_len (low_len),
        .rel_len (rel_len)
    );

    always_comb begin
        cur_len    = in_low_q ? low_len : rel_len;
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        sel_change = (sel_in != sel_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q.mode   <= DM_PIN_LOW;
            sel_q.status <= ST_NONE;
            in_low_q     <= 1'b1;
            cnt_q        <= '0;
        end else if (tick) begin
            if (sel_change) begin
                sel_q    <= sel_in;
                in_low_q <= 1'b1;
                cnt_q    <= '0;
            end else if (kind == PK_BLINK) begin
                if (cnt_inc >= {1'b0, cur_len}) begin
                    in_low_q <= ~in_low_q;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        drive_low = (kind == PK_LIT) || ((kind == PK_BLINK) && in_low_q);
    end

endmodule

// File: rtl/led_status_gen.sv
module led_status_gen
    import ledpat_pkg::*;
#(
    parameter int unsigned NUM_CELLS   = 2,
    parameter int unsigned SHORT_TICKS = 1,
    parameter int unsigned MID_TICKS   = 3,
    parameter int unsigned LONG_TICKS  = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [1:0]             disp_mode,
    input  logic [2*NUM_CELLS-1:0] cell_status,
    output logic [NUM_CELLS-1:0]   led_drive_low
);

    localparam int unsigned MAX_TICKS = (LONG_TICKS > MID_TICKS)
                                        ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                                        : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
    localparam int unsigned CNT_W = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS + 1);

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
        pat_sel_t cell_sel;

        always_comb begin
            cell_sel.mode   = disp_mode_e'(disp_mode);
            cell_sel.status = cell_status_e'(cell_status[2*gi +: 2]);
        end

        ledpat_phase #(
            .SHORT_TICKS (SHORT_TICKS),
            .MID_TICKS   (MID_TICKS),
            .LONG_TICKS  (LONG_TICKS),
            .CNT_W       (CNT_W)
        ) u_phase (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .sel_in    (cell_sel),
            .drive_low (led_drive_low[gi])
        );
    end

endmodule

// File: rtl/led_status_chk.sv
module led_status_chk #(
    parameter int unsigned NUM_CELLS = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic [1:0]             disp_mode,
    input logic [2*NUM_CELLS-1:0] cell_status,
    input logic [NUM_CELLS-1:0]   led_drive_low
);

    assert_reset_dark_R8: assert property (@(posedge clk)
        rst |=> (led_drive_low == '0));

    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(led_drive_low));

    assert_unused_mode_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && disp_mode == 2'd3) |=> (led_drive_low == '0));

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_chk
        assert_no_cell_dark_R1: assert property (@(posedge clk) disable iff (rst)
            (tick && cell_status[2*gi +: 2] == 2'd0) |=> !led_drive_low[gi]);

        assert_pinlow_charging_lit_R2: assert property (@(posedge clk) disable iff (rst)
            (tick && disp_mode == 2'd0 && cell_status[2*gi +: 2] == 2'd1) |=> led_drive_low[gi]);

        assert_open_maint_dark_R3: assert property (@(posedge clk) disable iff (rst)
            (tick && disp_mode == 2'd1 && cell_status[2*gi +: 2] == 2'd2) |=> !led_drive_low[gi]);

        assert_pinhigh_maint_lit_R4: assert property (@(posedge clk) disable iff (rst)
            (tick && disp_mode == 2'd2 && cell_status[2*gi +: 2] == 2'd2) |=> led_drive_low[gi]);
    end

endmodule

bind led_status_gen led_status_chk #(
    .NUM_CELLS (NUM_CELLS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .disp_mode     (disp_mode),
    .cell_status   (cell_status),
    .led_drive_low (led_drive_low)
);

// File: tb/sim_led_status_gen.sv
module sim_led_status_gen;

    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [1:0]    disp_mode = 2'd0;
    logic [2*NC-1:0] cell_status = '0;
    logic [NC-1:0] led_drive_low;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    led_status_gen #(.NUM_CELLS(NC)) u0 (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .disp_mode     (disp_mode),
        .cell_status   (cell_status),
        .led_drive_low (led_drive_low)
    );

    // {mode[1:0], status[1:0], expected low pattern, bit j = after j-th tick}
    localparam logic [13:0] VEC [15] = '{
        {2'd0, 2'd0, 10'b0000000000},
        {2'd0, 2'd1, 10'b1111111111},
        {2'd0, 2'd2, 10'b1111011111},
        {2'd0, 2'd3, 10'b0111000111},
        {2'd1, 2'd0, 10'b0000000000},
        {2'd1, 2'd1, 10'b1111111111},
        {2'd1, 2'd2, 10'b0000000000},
        {2'd1, 2'd3, 10'b0101010101},
        {2'd2, 2'd0, 10'b0000000000},
        {2'd2, 2'd1, 10'b1111011111},
        {2'd2, 2'd2, 10'b1111111111},
        {2'd2, 2'd3, 10'b0101010101},
        {2'd3, 2'd1, 10'b0000000000},
        {2'd3, 2'd3, 10'b0000000000},
        {2'd3, 2'd2, 10'b0000000000}
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic string req_of(input logic [1:0] m, input logic [1:0] s);
        if (s == 2'd0) return "R1";
        case (m)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    localparam logic [9:0] MAINT0 = 10'b1111011111;

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state, held dark until the first tick
        disp_mode   = 2'd0;
        cell_status = {2'd1, 2'd1};
        idle(3);
        check("R8 reset cell0", led_drive_low[0], 1'b0);
        rst = 1'b0;
        idle(5);
        check("R8 no tick yet cell0", led_drive_low[0], 1'b0);
        check("R8 no tick yet cell1", led_drive_low[1], 1'b0);

        // Table walk: R1..R6
        for (int v = 0; v < 15; v++) begin
            disp_mode   = VEC[v][13:12];
            cell_status = {VEC[v][11:10], VEC[v][11:10]};
            for (int j = 0; j < 10; j++) begin
                tick_once();
                idle(1);
                check(req_of(VEC[v][13:12], VEC[v][11:10]), led_drive_low[0], VEC[v][j]);
                check(req_of(VEC[v][13:12], VEC[v][11:10]), led_drive_low[1], VEC[v][j]);
            end
        end

        // R7 / R6: restart mid-pattern, no effect between ticks
        disp_mode   = 2'd0;
        cell_status = {2'd3, 2'd3};
        for (int j = 0; j < 4; j++) tick_once();
        check("R7 fault 3/3 in released phase", led_drive_low[0], 1'b0);
        disp_mode   = 2'd2;
        cell_status = {2'd1, 2'd1};
        idle(3);
        check("R7 change before tick ignored", led_drive_low[0], 1'b0);
        tick_once();
        check("R7 restart at low phase", led_drive_low[0], 1'b1);
        for (int j = 1; j < 5; j++) tick_once();
        check("R6 long interval still low at tick 4", led_drive_low[0], 1'b1);
        tick_once();
        check("R6 long interval ends after 5 ticks", led_drive_low[0], 1'b0);

        // R9: independent cells
        disp_mode   = 2'd0;
        cell_status = {2'd2, 2'd3};
        tick_once();
        check("R9 cell1 start", led_drive_low[1], MAINT0[0]);
        tick_once();
        tick_once();
        cell_status = {2'd2, 2'd1};
        for (int j = 3; j < 8; j++) begin
            tick_once();
            check("R9 cell1 undisturbed", led_drive_low[1], MAINT0[j]);
            check("R9 cell0 charging lit", led_drive_low[0], 1'b1);
        end

        // R8: reset in mid-run
        disp_mode   = 2'd1;
        cell_status = {2'd1, 2'd1};
        tick_once();
        check("R3 charging lit before reset", led_drive_low[0], 1'b1);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        check("R8 mid-run reset cell0", led_drive_low[0], 1'b0);
        check("R8 mid-run reset cell1", led_drive_low[1], 1'b0);
        tick_once();
        check("R8 lit again after first tick", led_drive_low[0], 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule